// File: doc/BRIEF.md
# Hot-Swap Power-Up Sequencer

This block decides when a plug-in card may close its external power pass switch. It watches six asynchronous flags from analog comparators and board pins: main supply above lockout, internal supply above threshold, input undervoltage OK, input overvoltage OK, an active-low enable, and an ON request. Each flag goes through a two-stage synchronizer before the state machine reads it.

The sequence runs in a fixed order. First both supplies must be good. Then a power-on reset pulse of programmable length clears the fault registers and loads the control defaults. Next the voltage-window and enable conditions must hold together, with no break, for a long debounce window that rejects contact bounce while the card is inserted. When that window ends, the ON level is captured into a control bit, and the gate is enabled either at once or when ON is later raised. Both intervals are given in physical units and turned into clock-cycle counts from the clock-frequency parameter.

Losing a supply at any point sends the block back to lockout, and it issues a fresh reset pulse when the supply returns. Losing a voltage-window or enable condition sends it back to qualification.

Top module: `hotswap_seq`

## Requirements
- R1: While either supply flag is low, the state stays lockout (code 0), and gate_en_o and regs_clear_o are low.
- R2: When both supply flags are high, regs_clear_o goes high and stays high for exactly RST_CYC = CLK_HZ*RST_US/1e6 clock cycles (at least 1), while the state shows reset (code 1).
- R3: The reset pulse forces on_latched_o to its default of 0, even when it was 1 before the supply was lost.
- R4: The qualification window advances only while uv_ok_i and ov_ok_i are high and en_n_i is low. Otherwise the state stays qualify (code 2) with the gate off.
- R5: Any input change reaches the state three clock edges after it is applied (two synchronizer stages plus the state register). When the conditions are already true on entry to qualify, the qualify state lasts exactly QUAL_CYC = CLK_HZ*QUAL_MS/1000 cycles.
- R6: If any qualifying condition drops, even for one cycle, the window restarts from zero. The exit then comes QUAL_CYC cycles after the condition is seen true again.
- R7: At the end of the window the synchronized ON level is written to on_latched_o. If that level is 1, the state goes straight to gate-on (code 4).
- R8: If the captured ON level is 0, the state goes to wait-on (code 3) with the gate off. It moves to gate-on when ON rises, and on_latched_o keeps its captured value.
- R9: In wait-on or gate-on, loss of any qualifying condition returns the state to qualify and drops the gate.
- R10: Loss of either supply flag in any state returns the state to lockout and drops the gate. On recovery a new reset pulse is issued.
- R11: gate_en_o is high exactly when the state is gate-on (code 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the digital logic |
| ext_ok_i | input | 1 | Main supply above lockout (asynchronous) |
| int_ok_i | input | 1 | Internal supply above threshold (asynchronous) |
| uv_ok_i | input | 1 | Input above undervoltage level (asynchronous) |
| ov_ok_i | input | 1 | Input below overvoltage level (asynchronous) |
| en_n_i | input | 1 | Active-low card enable (asynchronous) |
| on_i | input | 1 | ON request (asynchronous) |
| gate_en_o | output | 1 | Enable for the external pass-switch gate drive |
| regs_clear_o | output | 1 | Reset pulse: clear faults, load control defaults |
| on_latched_o | output | 1 | Control bit holding the ON level captured at qualification |
| state_o | output | 3 | Encoded state: 0 lockout, 1 reset, 2 qualify, 3 wait-on, 4 gate-on |

## Verification
The bench counts cycles at the ports to check the exact width of the reset pulse and the exact length of the debounce window. A window that is one cycle too short or too long would move the gate edge, and the bench samples the cycle before and the cycle of that edge. Condition glitches of random length and position are placed inside the window. A design that paused the count instead of restarting it would enable the gate early. The bench also checks that a supply lost during the reset pulse or while the gate is on returns the block to lockout and that recovery clears a previously set ON bit; a design that skipped the second reset would leave that bit at 1. Last, ON is captured both high and low. A design that tracked the pin instead of latching it would change on_latched_o when ON rises in wait-on.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
    typedef enum logic [2:0] {
        ST_LOCKOUT = 3'd0,
        ST_RESET   = 3'd1,
        ST_QUALIFY = 3'd2,
        ST_WAIT_ON = 3'd3,
        ST_GATE_ON = 3'd4
    } hsw_state_e;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[i];
                stab_q <= meta_q;
            end
        end
        assign sync_o[i] = stab_q;
    end
endmodule

// File: rtl/hsw_timer.sv
module hsw_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    input  logic [CW-1:0] limit_i,
    output logic          done_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clr_i) begin
            tmr_d.cnt = '0;
        end else if (inc_i) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done_o = (tmr_q.cnt == limit_i - 1'b1);

    // R6: a restart request leaves the counter at zero
    a_r6_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (tmr_q.cnt == '0));

    // R5: the counter never passes the active interval
    a_r5_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt < limit_i);
endmodule

// File: rtl/hsw_fsm.sv
module hsw_fsm
    import hsw_pkg::*;
#(
    parameter int unsigned CW       = 8,
    parameter int unsigned RST_CYC  = 4,
    parameter int unsigned QUAL_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_ok,
    input  logic          int_ok,
    input  logic          uv_ok,
    input  logic          ov_ok,
    input  logic          en_n,
    input  logic          on_req,
    input  logic          tmr_done,
    output logic          tmr_clr,
    output logic          tmr_inc,
    output logic [CW-1:0] tmr_limit,
    output logic          gate_en,
    output logic          regs_clear,
    output logic          on_latched,
    output hsw_state_e    state
);
    localparam logic [CW-1:0] RST_L  = RST_CYC[CW-1:0];
    localparam logic [CW-1:0] QUAL_L = QUAL_CYC[CW-1:0];

    typedef struct packed {
        hsw_state_e st;
        logic       on_lat;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic supplies_ok;
    logic qual_ok;

    assign supplies_ok = ext_ok & int_ok;
    assign qual_ok     = uv_ok & ov_ok & ~en_n;

    always_comb begin
        fsm_d     = fsm_q;
        tmr_clr   = 1'b0;
        tmr_inc   = 1'b0;
        tmr_limit = (fsm_q.st == ST_RESET) ? RST_L : QUAL_L;
        unique case (fsm_q.st)
            ST_LOCKOUT: begin
                tmr_clr = 1'b1;
                if (supplies_ok) fsm_d.st = ST_RESET;
            end
            ST_RESET: begin
                fsm_d.on_lat = 1'b0;
                if (tmr_done) begin
                    fsm_d.st = ST_QUALIFY;
                    tmr_clr  = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_QUALIFY: begin
                if (!qual_ok) begin
                    tmr_clr = 1'b1;
                end else if (tmr_done) begin
                    fsm_d.on_lat = on_req;
                    fsm_d.st     = on_req ? ST_GATE_ON : ST_WAIT_ON;
                    tmr_clr      = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_WAIT_ON: begin
                tmr_clr = 1'b1;
                if (!qual_ok)    fsm_d.st = ST_QUALIFY;
                else if (on_req) fsm_d.st = ST_GATE_ON;
            end
            ST_GATE_ON: begin
                tmr_clr = 1'b1;
                if (!qual_ok) fsm_d.st = ST_QUALIFY;
            end
            default: begin
                fsm_d.st = ST_LOCKOUT;
                tmr_clr  = 1'b1;
            end
        endcase
        if (!supplies_ok) begin
            fsm_d.st = ST_LOCKOUT;
            tmr_clr  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_LOCKOUT, on_lat: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state      = fsm_q.st;
    assign gate_en    = (fsm_q.st == ST_GATE_ON);
    assign regs_clear = (fsm_q.st == ST_RESET);
    assign on_latched = fsm_q.on_lat;

    // R1: without both supplies the block does not leave lockout
    a_r1_hold_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_LOCKOUT && !supplies_ok) |=> (fsm_q.st == ST_LOCKOUT));

    // R10: a lost supply removes the gate on the next edge
    a_r10_supply_loss_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !supplies_ok |=> !gate_en);

    // R3: the ON bit is at its default after a reset cycle
    a_r3_on_bit_default: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_RESET) |=> !fsm_q.on_lat);

    // R7: the gate only opens from qualify or wait-on
    a_r7_gate_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> ($past(fsm_q.st) == ST_QUALIFY || $past(fsm_q.st) == ST_WAIT_ON));

    // R8: the captured ON bit stays put outside qualify and reset
    a_r8_on_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_WAIT_ON || fsm_q.st == ST_GATE_ON) |=> $stable(fsm_q.on_lat));

    // R9: a dropped condition ends gate-on
    a_r9_cond_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_GATE_ON && !qual_ok) |=> !gate_en);
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq
    import hsw_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned RST_US  = 90,
    parameter int unsigned QUAL_MS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_ok_i,
    input  logic       int_ok_i,
    input  logic       uv_ok_i,
    input  logic       ov_ok_i,
    input  logic       en_n_i,
    input  logic       on_i,
    output logic       gate_en_o,
    output logic       regs_clear_o,
    output logic       on_latched_o,
    output logic [2:0] state_o
);
    localparam logic [63:0]  RST_RAW  = (64'(CLK_HZ) * 64'(RST_US)) / 64'd1_000_000;
    localparam logic [63:0]  QUAL_RAW = (64'(CLK_HZ) * 64'(QUAL_MS)) / 64'd1_000;
    localparam int unsigned  RST_CYC  = (RST_RAW  < 64'd1) ? 1 : int'(RST_RAW);
    localparam int unsigned  QUAL_CYC = (QUAL_RAW < 64'd1) ? 1 : int'(QUAL_RAW);
    localparam int unsigned  MAX_CYC  = (QUAL_CYC > RST_CYC) ? QUAL_CYC : RST_CYC;
    localparam int unsigned  CW       = $clog2(MAX_CYC + 1);
    localparam int unsigned  NSYNC    = 6;

    logic [NSYNC-1:0] raw_vec;
    logic [NSYNC-1:0] syn_vec;
    logic             tmr_clr;
    logic             tmr_inc;
    logic             tmr_done;
    logic [CW-1:0]    tmr_limit;
    hsw_state_e       st;

    assign raw_vec = {on_i, en_n_i, ov_ok_i, uv_ok_i, int_ok_i, ext_ok_i};

    hsw_sync #(.N(NSYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_vec),
        .sync_o  (syn_vec)
    );

    hsw_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .inc_i   (tmr_inc),
        .limit_i (tmr_limit),
        .done_o  (tmr_done)
    );

    hsw_fsm #(
        .CW       (CW),
        .RST_CYC  (RST_CYC),
        .QUAL_CYC (QUAL_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_ok     (syn_vec[0]),
        .int_ok     (syn_vec[1]),
        .uv_ok      (syn_vec[2]),
        .ov_ok      (syn_vec[3]),
        .en_n       (syn_vec[4]),
        .on_req     (syn_vec[5]),
        .tmr_done   (tmr_done),
        .tmr_clr    (tmr_clr),
        .tmr_inc    (tmr_inc),
        .tmr_limit  (tmr_limit),
        .gate_en    (gate_en_o),
        .regs_clear (regs_clear_o),
        .on_latched (on_latched_o),
        .state      (st)
    );

    assign state_o = st;

    // R11: the gate output and the gate-on code agree
    a_r11_gate_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en_o == (state_o == 3'd4));
endmodule

// File: tb/tb_hotswap_seq.sv
module tb_hotswap_seq;
    localparam int unsigned CLK_HZ  = 100_000;
    localparam int unsigned RST_US  = 90;
    localparam int unsigned QUAL_MS = 100;

    function automatic int exp_cycles(input longint hz, input longint units, input longint per_s);
        longint v;
        v = (hz * units) / per_s;
        return (v < 1) ? 1 : int'(v);
    endfunction

    function automatic int exp_qual_state(input bit on_lvl);
        return on_lvl ? 4 : 3;
    endfunction

    localparam int RCYC = 9;
    localparam int QCYC = 10_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_ok = 1'b0, int_ok = 1'b0, uv_ok = 1'b0, ov_ok = 1'b0;
    logic       en_n = 1'b1, on_in = 1'b0;
    logic       gate_en, regs_clear, on_latched;
    logic [2:0] state;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hotswap_seq #(.CLK_HZ(CLK_HZ), .RST_US(RST_US), .QUAL_MS(QUAL_MS)) dut (
        .clk(clk), .rst_n(rst_n),
        .ext_ok_i(ext_ok), .int_ok_i(int_ok), .uv_ok_i(uv_ok), .ov_ok_i(ov_ok),
        .en_n_i(en_n), .on_i(on_in),
        .gate_en_o(gate_en), .regs_clear_o(regs_clear),
        .on_latched_o(on_latched), .state_o(state)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // measure reset pulse width after supplies come good (R2)
    task automatic measure_reset(input string tag);
        int len = 0;
        int guard = 0;
        while (!regs_clear && guard < 12) begin
            @(negedge clk);
            guard++;
        end
        while (regs_clear) begin
            if (state != 3'd1) chk_eq({tag, " state during pulse"}, state, 1);
            len++;
            @(negedge clk);
        end
        chk_eq(tag, len, RCYC);
    endtask

    // after inputs become good at a negedge, the exit happens QCYC+2 edges later (R5/R6)
    task automatic check_exit(input string tag, input bit on_lvl);
        cyc(QCYC + 1);
        chk_eq({tag, " still qualifying one cycle before exit"}, state, 2);
        cyc(1);
        chk_eq({tag, " state at exit"}, state, exp_qual_state(on_lvl));
        chk_eq({tag, " captured ON"}, on_latched, on_lvl);
        chk_eq({tag, " gate"}, gate_en, on_lvl);
    endtask

    initial begin
        int wd = 0;
        while (!finished) begin
            @(posedge clk);
            wd++;
            if (wd > 190_000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", wd, 190_000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int len;
        void'($urandom(32'd20240611));
        chk_eq("bench R2 cycle formula", exp_cycles(CLK_HZ, RST_US, 1_000_000), RCYC);
        chk_eq("bench R5 cycle formula", exp_cycles(CLK_HZ, QUAL_MS, 1_000), QCYC);

        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk_eq("reset state R11 lockout code", state, 0);
        chk_eq("reset gate R11", gate_en, 0);
        chk_eq("reset pulse idle R1", regs_clear, 0);
        chk_eq("reset ON bit R3", on_latched, 0);

        // R1: only one supply good at a time
        ext_ok = 1'b1;
        cyc(20);
        chk_eq("R1 ext only state", state, 0);
        chk_eq("R1 ext only pulse", regs_clear, 0);
        ext_ok = 1'b0; int_ok = 1'b1;
        cyc(20);
        chk_eq("R1 int only state", state, 0);
        chk_eq("R1 int only gate", gate_en, 0);

        // R10: supply lost in the middle of the reset pulse
        uv_ok = 1'b1; ov_ok = 1'b1; en_n = 1'b1; on_in = 1'b1;
        ext_ok = 1'b1;
        cyc(5);
        chk_eq("R10 pulse started", regs_clear, 1);
        ext_ok = 1'b0;
        cyc(3);
        chk_eq("R10 lockout from reset", state, 0);
        chk_eq("R10 pulse ended", regs_clear, 0);

        // R2: full pulse
        ext_ok = 1'b1;
        measure_reset("R2 pulse width");
        chk_eq("R2 qualify after pulse", state, 2);
        chk_eq("R3 ON bit default", on_latched, 0);

        // R4: enable high blocks qualification
        cyc(QCYC + 20);
        chk_eq("R4 enable high holds qualify", state, 2);
        chk_eq("R4 gate off", gate_en, 0);

        // R5 + R7: release enable with ON high
        en_n = 1'b0;
        check_exit("R5 R7 ON high", 1'b1);

        // R10 + R3: supply loss while gate on, recovery clears ON bit
        int_ok = 1'b0;
        cyc(2);
        chk_eq("R10 gate held two edges", gate_en, 1);
        cyc(1);
        chk_eq("R10 lockout from gate-on", state, 0);
        chk_eq("R10 gate dropped", gate_en, 0);
        int_ok = 1'b1;
        measure_reset("R10 new pulse width");
        chk_eq("R3 ON bit cleared by new pulse", on_latched, 0);

        // R5: conditions already true on entry, count qualify length
        len = 0;
        while (state == 3'd2 && len < QCYC + 10) begin
            len++;
            @(negedge clk);
        end
        chk_eq("R5 qualify length", len, QCYC);
        chk_eq("R7 gate on after steady window", state, 4);
        chk_eq("R7 ON captured high", on_latched, 1);

        // R9: condition loss while gate on
        ov_ok = 1'b0;
        cyc(2);
        chk_eq("R9 gate held two edges", gate_en, 1);
        cyc(1);
        chk_eq("R9 back to qualify", state, 2);
        chk_eq("R9 gate dropped", gate_en, 0);
        chk_eq("R9 ON bit kept", on_latched, 1);

        // R8: ON low at capture
        on_in = 1'b0;
        ov_ok = 1'b1;
        check_exit("R8 ON low", 1'b0);
        cyc(50);
        chk_eq("R8 waits for ON", state, 3);
        on_in = 1'b1;
        cyc(2);
        chk_eq("R8 not yet gated", gate_en, 0);
        cyc(1);
        chk_eq("R8 gate after ON rises", state, 4);
        chk_eq("R8 ON bit unchanged", on_latched, 0);

        // R9 from wait-on
        on_in = 1'b0;
        uv_ok = 1'b0;
        cyc(3);
        chk_eq("R9 leaves gate to qualify", state, 2);
        uv_ok = 1'b1;
        check_exit("R9 requalify ON low", 1'b0);
        en_n = 1'b1;
        cyc(3);
        chk_eq("R9 wait-on to qualify", state, 2);

        // R6: random glitches inside the window
        for (int it = 0; it < 4; it++) begin
            int pos;
            int glen;
            int which;
            bit onr;
            pos   = 100 + int'($urandom % (QCYC - 200));
            glen  = 1 + int'($urandom % 30);
            which = int'($urandom % 3);
            onr   = 1'($urandom % 2);
            en_n = 1'b0;
            cyc(pos);
            chk_eq("R6 in window before glitch", state, 2);
            case (which)
                0: uv_ok = 1'b0;
                1: ov_ok = 1'b0;
                default: en_n = 1'b1;
            endcase
            cyc(glen);
            uv_ok = 1'b1; ov_ok = 1'b1; en_n = 1'b0; on_in = onr;
            check_exit("R6 restart after glitch", onr);
            en_n = 1'b1;
            cyc(3);
            chk_eq("R6 back to qualify", state, 2);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule